// File: doc/BRIEF.md
# Posted Transaction Admission Buffer

This block sits between the target side of a PCI interface and the master side of a processor bus. It buffers the transactions that pass from one side to the other in two independent queues. One queue holds command words and takes one entry per transaction. The other holds 64-bit data beats and takes one entry per beat. The same data queue serves read data and write data. A new transaction is admitted only when both queues can take all of it. Posting capacity is therefore limited by whichever queue runs out first. A single full-length burst exhausts the data queue, and a handful of single-beat transactions exhausts the command queue. While either queue is short of room, the target-ready output stays low, which holds off the PCI data phase until the master side drains entries.

The requester raises `req_valid` and holds `req_beats` and `req_cmd` steady until the transaction is taken. The command is written on the cycle in which `req_valid` and `req_ready` are both high. That same cycle reserves `req_beats` data slots. The beats then arrive on `beat_valid`/`beat_data` starting on the following cycle. The master side drains each queue through its own show-ahead pop port. When posting is switched off, the block admits a transaction only once everything earlier has left both queues.

Top module: `posted_admit`

## Requirements
- R1: During and right after reset, `req_ready`, `cmd_valid` and `dat_valid` are all low, and both queues are empty.
- R2: A request that fits is signalled ready in the cycle after `req_valid` rises. It fits when the command queue has a free slot and the data space exceeds or equals `req_beats`, where data space is DATA_DEPTH minus stored beats minus reserved beats. A transaction is taken on a clock edge where `req_valid` and `req_ready` are both high.
- R3: Once CMD_DEPTH commands are held, `req_ready` stays low for any request size. Popping one command lets a waiting request be signalled ready in the next cycle.
- R4: Once a DATA_DEPTH-beat burst has been taken, a 1-beat request stays blocked. Popping one data beat lets it be signalled ready in the next cycle.
- R5: In the cycle after a transaction is taken, `req_ready` is low.
- R6: A request with `req_beats` equal to 0 or greater than DATA_DEPTH is never signalled ready.
- R7: Each cycle with `beat_valid` high while reserved beats remain stores one data entry and lowers the reservation by one. Beats of a transaction start in the cycle after it is taken. A beat offered with no reservation outstanding is dropped and never appears at the data pop port.
- R8: Commands and data beats leave in the order they entered. `cmd_valid` and `dat_valid` are high exactly when their queue is non-empty, and an entry leaves on a clock edge with its pop input and valid both high.
- R9: With `post_en` low, a request is signalled ready only when both queues are empty and no reservation is outstanding.
- R10: Reserved but not yet written beats count as occupied. A request that would fit the stored beats alone, but not the stored plus reserved beats, stays blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| post_en | input | 1 | High allows several posted transactions in flight |
| req_valid | input | 1 | A transaction is offered |
| req_beats | input | $clog2(DATA_DEPTH+1) | Number of 64-bit data beats of the offered transaction |
| req_cmd | input | CMD_W | Command word of the offered transaction |
| req_ready | output | 1 | Registered target-ready; transaction taken when high with req_valid |
| beat_valid | input | 1 | A data beat is offered |
| beat_data | input | DATA_W | Data beat |
| cmd_valid | output | 1 | Command queue non-empty |
| cmd_data | output | CMD_W | Oldest command word |
| cmd_pop | input | 1 | Remove oldest command |
| dat_valid | output | 1 | Data queue non-empty |
| dat_data | output | DATA_W | Oldest data beat |
| dat_pop | input | 1 | Remove oldest data beat |

## Verification
The bench builds the block with its default sizes: 64-bit data, a 16-entry data queue, a 52-bit command word and a 4-entry command queue. At these sizes, one 16-beat burst fills the data side. Four single-beat transactions fill the command side. These are the two cases that show each queue acting as the limit. The small command depth also keeps the non-posting and reservation cases short, so each blocked and unblocked transition can be checked cycle by cycle.

// File: rtl/posted_admit.sv
module posted_admit #(
  parameter int DATA_W     = 64,
  parameter int DATA_DEPTH = 16,
  parameter int CMD_W      = 52,
  parameter int CMD_DEPTH  = 4,
  localparam int BW        = $clog2(DATA_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              post_en,
  input  logic              req_valid,
  input  logic [BW-1:0]     req_beats,
  input  logic [CMD_W-1:0]  req_cmd,
  output logic              req_ready,
  input  logic              beat_valid,
  input  logic [DATA_W-1:0] beat_data,
  output logic              cmd_valid,
  output logic [CMD_W-1:0]  cmd_data,
  input  logic              cmd_pop,
  output logic              dat_valid,
  output logic [DATA_W-1:0] dat_data,
  input  logic              dat_pop
);
  localparam int DAW = (DATA_DEPTH > 1) ? $clog2(DATA_DEPTH) : 1;
  localparam int CAW = (CMD_DEPTH > 1) ? $clog2(CMD_DEPTH) : 1;
  localparam int CCW = $clog2(CMD_DEPTH + 1);

  logic [DATA_W-1:0] dmem [DATA_DEPTH];
  logic [CMD_W-1:0]  cmem [CMD_DEPTH];
  logic [DAW-1:0]    dwp, drp;
  logic [CAW-1:0]    cwp, crp;
  logic [BW-1:0]     dcnt, resv;
  logic [CCW-1:0]    ccnt;
  logic              rdy_q;

  logic              take, cpop, dpop, dwr, fits;
  logic [CCW-1:0]    ccnt_n;
  logic [BW-1:0]     dcnt_n, resv_n;
  logic [BW:0]       dfree_n;

  function automatic logic [DAW-1:0] dinc(input logic [DAW-1:0] p);
    return (p == DAW'(DATA_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [CAW-1:0] cinc(input logic [CAW-1:0] p);
    return (p == CAW'(CMD_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign take = req_valid & rdy_q;
  assign cpop = cmd_pop & (ccnt != '0);
  assign dpop = dat_pop & (dcnt != '0);
  assign dwr  = beat_valid & (resv != '0);

  always_comb begin
    ccnt_n  = ccnt + CCW'(take) - CCW'(cpop);
    dcnt_n  = dcnt + BW'(dwr) - BW'(dpop);
    resv_n  = resv - BW'(dwr) + (take ? req_beats : '0);
    dfree_n = (BW+1)'(DATA_DEPTH) - {1'b0, dcnt_n} - {1'b0, resv_n};
    fits    = req_valid && !take
           && (req_beats != '0)
           && ({1'b0, req_beats} <= dfree_n)
           && (ccnt_n < CCW'(CMD_DEPTH))
           && (post_en || (ccnt_n == '0 && dcnt_n == '0 && resv_n == '0));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ccnt  <= '0;
      dcnt  <= '0;
      resv  <= '0;
      cwp   <= '0;
      crp   <= '0;
      dwp   <= '0;
      drp   <= '0;
      rdy_q <= 1'b0;
    end else begin
      ccnt  <= ccnt_n;
      dcnt  <= dcnt_n;
      resv  <= resv_n;
      rdy_q <= fits;
      if (take) cwp <= cinc(cwp);
      if (cpop) crp <= cinc(crp);
      if (dwr)  dwp <= dinc(dwp);
      if (dpop) drp <= dinc(drp);
    end
  end

  always_ff @(posedge clk) begin
    if (take) cmem[cwp] <= req_cmd;
    if (dwr)  dmem[dwp] <= beat_data;
  end

  assign req_ready = rdy_q;
  assign cmd_valid = (ccnt != '0);
  assign dat_valid = (dcnt != '0);
  assign cmd_data  = cmem[crp];
  assign dat_data  = dmem[drp];
endmodule

// File: rtl/posted_admit_chk.sv
module posted_admit_chk #(
  parameter int DATA_DEPTH = 16,
  parameter int CMD_DEPTH  = 4,
  localparam int BW        = $clog2(DATA_DEPTH + 1),
  localparam int CCW       = $clog2(CMD_DEPTH + 1)
) (
  input logic           clk,
  input logic           rst,
  input logic           post_en,
  input logic           req_valid,
  input logic           req_ready,
  input logic [BW-1:0]  req_beats,
  input logic           beat_valid,
  input logic [CCW-1:0] ccnt,
  input logic [BW-1:0]  dcnt,
  input logic [BW-1:0]  resv
);
  p_cmd_bound_r3: assert property (@(posedge clk) disable iff (rst)
    int'(ccnt) <= CMD_DEPTH);

  p_data_bound_r4: assert property (@(posedge clk) disable iff (rst)
    int'(dcnt) + int'(resv) <= DATA_DEPTH);

  p_take_fits_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |->
      (int'(ccnt) < CMD_DEPTH && req_beats != '0 &&
       int'(req_beats) <= DATA_DEPTH - int'(dcnt) - int'(resv)));

  p_bubble_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  p_size_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_beats == '0 || int'(req_beats) > DATA_DEPTH)) |-> !req_ready);

  p_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && resv == '0) |=> int'(dcnt) <= int'($past(dcnt)));

  p_single_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !post_en) |->
      (ccnt == '0 && dcnt == '0 && resv == '0));
endmodule

bind posted_admit posted_admit_chk #(.DATA_DEPTH(DATA_DEPTH), .CMD_DEPTH(CMD_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .post_en(post_en), .req_valid(req_valid),
  .req_ready(req_ready), .req_beats(req_beats), .beat_valid(beat_valid),
  .ccnt(ccnt), .dcnt(dcnt), .resv(resv)
);

// File: tb/sim_posted_admit.sv
module sim_posted_admit;
  logic clk = 1'b0, rst = 1'b1, post_en = 1'b1;
  logic req_valid = 1'b0, beat_valid = 1'b0, cmd_pop = 1'b0, dat_pop = 1'b0;
  logic [4:0]  req_beats = '0;
  logic [51:0] req_cmd = '0;
  logic [63:0] beat_data = '0;
  logic        req_ready, cmd_valid, dat_valid;
  logic [51:0] cmd_data;
  logic [63:0] dat_data;

  int n_chk = 0, n_bad = 0;
  logic [51:0] cq[$];
  logic [63:0] dq[$];
  logic [63:0] dseq = 64'hD000_0000_0000_0001;

  always #2.5 clk = ~clk;

  posted_admit u0 (
    .clk(clk), .rst(rst), .post_en(post_en), .req_valid(req_valid),
    .req_beats(req_beats), .req_cmd(req_cmd), .req_ready(req_ready),
    .beat_valid(beat_valid), .beat_data(beat_data), .cmd_valid(cmd_valid),
    .cmd_data(cmd_data), .cmd_pop(cmd_pop), .dat_valid(dat_valid),
    .dat_data(dat_data), .dat_pop(dat_pop)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input int beats, input logic [51:0] c, input string req);
    int w = 0;
    @(negedge clk);
    req_valid = 1'b1; req_beats = 5'(beats); req_cmd = c;
    @(negedge clk);
    while (!req_ready && w < 40) begin @(negedge clk); w++; end
    chk(w == 0, req, w, 0);
    @(posedge clk);
    cq.push_back(c);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R5", req_ready, 0);
  endtask

  task automatic push_beats(input int n);
    for (int i = 0; i < n; i++) begin
      beat_valid = 1'b1; beat_data = dseq; dq.push_back(dseq); dseq++;
      @(negedge clk);
    end
    beat_valid = 1'b0;
  endtask

  task automatic pop_cmd(input string req);
    chk(cmd_valid, req, cmd_valid, 1);
    chk(cmd_data == cq[0], req, cmd_data, cq[0]);
    void'(cq.pop_front());
    cmd_pop = 1'b1;
    @(negedge clk);
    cmd_pop = 1'b0;
  endtask

  task automatic pop_dat(input string req);
    chk(dat_valid, req, dat_valid, 1);
    chk(dat_data == dq[0], req, dat_data, dq[0]);
    void'(dq.pop_front());
    dat_pop = 1'b1;
    @(negedge clk);
    dat_pop = 1'b0;
  endtask

  task automatic drain(input string req);
    while (cq.size() != 0) pop_cmd(req);
    while (dq.size() != 0) pop_dat(req);
    chk(!cmd_valid && !dat_valid, req, {cmd_valid, dat_valid}, 0);
  endtask

  task automatic blocked(input int beats, input logic [51:0] c, input int n, input string req);
    req_valid = 1'b1; req_beats = 5'(beats); req_cmd = c;
    repeat (n) begin
      @(negedge clk);
      chk(!req_ready, req, req_ready, 0);
    end
  endtask

  task automatic take_now(input string req);
    chk(req_ready, req, req_ready, 1);
    @(posedge clk);
    cq.push_back(req_cmd);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(!req_ready && !cmd_valid && !dat_valid, "R1", {req_ready, cmd_valid, dat_valid}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!req_ready && !cmd_valid && !dat_valid, "R1", {req_ready, cmd_valid, dat_valid}, 0);
  endtask

  task automatic t_basic();
    send(2, 52'hA_0001, "R2");
    push_beats(2);
    drain("R8");
  endtask

  task automatic t_cmd_limit();
    for (int i = 0; i < 4; i++) begin
      send(1, 52'hC_0000 + 52'(i), "R2");
      push_beats(1);
    end
    blocked(1, 52'hC_0004, 5, "R3");
    pop_cmd("R8");
    take_now("R3");
    push_beats(1);
    drain("R8");
  endtask

  task automatic t_data_limit();
    send(16, 52'hB_0001, "R4");
    push_beats(16);
    blocked(1, 52'hB_0002, 5, "R4");
    pop_dat("R8");
    take_now("R4");
    push_beats(1);
    drain("R8");
  endtask

  task automatic t_reserve();
    send(10, 52'hE_0001, "R10");
    blocked(7, 52'hE_0002, 4, "R10");
    req_valid = 1'b0;
    send(6, 52'hE_0003, "R10");
    push_beats(16);
    drain("R10");
  endtask

  task automatic t_drop();
    send(2, 52'hF_0001, "R7");
    push_beats(2);
    beat_valid = 1'b1; beat_data = 64'hBAD0;
    @(negedge clk);
    beat_valid = 1'b0;
    drain("R7");
    beat_valid = 1'b1; beat_data = 64'hBAD1;
    @(negedge clk);
    beat_valid = 1'b0;
    @(negedge clk);
    chk(!dat_valid, "R7", dat_valid, 0);
  endtask

  task automatic t_bad_size();
    blocked(0, 52'h1, 4, "R6");
    req_valid = 1'b0;
    @(negedge clk);
    blocked(17, 52'h2, 4, "R6");
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_nopost();
    post_en = 1'b0;
    send(1, 52'h9_0001, "R9");
    push_beats(1);
    blocked(1, 52'h9_0002, 4, "R9");
    pop_cmd("R9");
    chk(!req_ready, "R9", req_ready, 0);
    pop_dat("R9");
    take_now("R9");
    push_beats(1);
    drain("R9");
    post_en = 1'b1;
  endtask

  initial begin
    #500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_cmd_limit();
    t_data_limit();
    t_reserve();
    t_drop();
    t_bad_size();
    t_nopost();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule